// File: doc/BRIEF.md
# Multi-Mode Cycle Interrupt Timer

This block is a 16-bit interrupt timer that moves at most once per clock, on cycles where the `tick` enable is high. A 3-bit mode select picks one of seven counting rules at run time. Four rules count up and three count down. They differ in how the pending line behaves: it can follow a comparison as a level, latch until acknowledged, clear itself at a second count, or arm only once before the enable drops.

A host programs the timer through a set of write strobes. Each strobe carries its own data and sets one field: counter, enable, pending or the reload value. A separate strobe loads the reload value into the counter, and an acknowledge strobe clears pending. The threshold, mask, fire count and acknowledge count are plain inputs that the host holds steady. The block drives the pending line towards an interrupt controller and shows the live counter value.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset the counter, enable, pending and reload value are all zero.
- R2: Mode 0 (masked level): an enabled tick loads the counter with (counter+1) AND mask. On the same tick, pending becomes (new counter >= threshold), so pending falls again after the masked counter wraps below the threshold.
- R3: Mode 1 (restart): an enabled tick increments the counter. If the result is >= threshold, the counter becomes 0 and pending is set.
- R4: Mode 2 (one-shot up): an enabled tick increments the counter. If the result equals the threshold, pending is set and enable is cleared, so the counter stops until the host enables it again.
- R5: Mode 3 (window): an enabled tick increments the counter. A result equal to the fire count sets pending. Otherwise, a result equal to the acknowledge count clears pending. With 4096/8192, pending rises on tick 4096 and falls on tick 8192.
- R6: Mode 4 (down and hold): a tick with enable high and a nonzero counter decrements it and sets pending when the result is 0. At 0 the counter holds and never fires again.
- R7: Mode 5 (one-shot down): an enabled tick on a counter of 0 sets pending, clears enable and leaves the counter at 0. On any other value the tick decrements. Starting from 5, tick six fires.
- R8: Mode 6 (free-running down): every tick decrements with wraparound, whatever the enable. Pending is set only when the result is 0xFFFF and enable is high.
- R9: In modes 0 to 5, a tick with enable low changes neither the counter nor pending.
- R10: `ack_strobe` clears pending. `rld_strobe` copies the stored reload value into the counter. The four host write strobes each set their field to the write data.
- R11: In one cycle, a host write to a field overrides the tick update of that field. The counter write overrides the reload strobe, and the pending write overrides acknowledge. Acknowledge overrides a fire for pending only, and the counter still takes its tick update.
- R12: Mode 7 is inert: ticks change neither the counter nor pending, even with enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Advance the timer this cycle |
| mode | input | 3 | Counting rule, codes 0 to 7 |
| thresh | input | 16 | Threshold for modes 0, 1 and 2 |
| mask | input | 16 | Counter mask for mode 0 |
| fire_cnt | input | 16 | Count that raises pending in mode 3 |
| ack_cnt | input | 16 | Count that clears pending in mode 3 |
| cnt_we | input | 1 | Write the counter |
| cnt_wdata | input | 16 | Counter write data |
| en_we | input | 1 | Write the enable |
| en_wdata | input | 1 | Enable write data |
| pend_we | input | 1 | Write the pending flag |
| pend_wdata | input | 1 | Pending write data |
| rld_we | input | 1 | Write the reload value |
| rld_wdata | input | 16 | Reload write data |
| rld_strobe | input | 1 | Copy the reload value into the counter |
| ack_strobe | input | 1 | Clear pending |
| irq_pending | output | 1 | Pending interrupt line |
| count_value | output | 16 | Current counter value |

## Verification
The main collision is a host action and a tick update in the same cycle. One case is an acknowledge on the cycle a down count reaches zero. Another is a counter write or reload strobe on a ticking cycle. The random phase raises every strobe with a small probability while ticks run in every mode, so these collisions occur many times. Directed cases also force them exactly: an acknowledge together with the firing tick, and a counter write together with a tick. The results are judged against the priority order in R11: the written field keeps the host value, and the other fields keep their tick update.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;

    typedef enum logic [2:0] {
        MODE_UP_LEVEL   = 3'd0,
        MODE_UP_RESTART = 3'd1,
        MODE_UP_ONESHOT = 3'd2,
        MODE_UP_WINDOW  = 3'd3,
        MODE_DN_HOLD    = 3'd4,
        MODE_DN_ONESHOT = 3'd5,
        MODE_DN_FREE    = 3'd6,
        MODE_IDLE       = 3'd7
    } irq_mode_e;

    // Comparison results on the current and candidate counter values
    typedef struct packed {
        logic inc_ge_thr;
        logic inc_eq_thr;
        logic msk_ge_thr;
        logic inc_eq_fire;
        logic inc_eq_ack;
        logic cur_zero;
        logic dec_zero;
        logic dec_ones;
    } cmp_flags_t;

endpackage

// File: rtl/cyc_irq_cmp.sv
module cyc_irq_cmp
    import cyc_irq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] thresh,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] fire_cnt,
    input  logic [W-1:0] ack_cnt,
    output logic [W-1:0] inc,
    output logic [W-1:0] inc_msk,
    output logic [W-1:0] dec,
    output cmp_flags_t   flags
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ONES = '1;

    always_comb begin
        inc               = cnt + ONE;
        inc_msk           = inc & mask;
        dec               = cnt - ONE;
        flags.inc_ge_thr  = (inc >= thresh);
        flags.inc_eq_thr  = (inc == thresh);
        flags.msk_ge_thr  = (inc_msk >= thresh);
        flags.inc_eq_fire = (inc == fire_cnt);
        flags.inc_eq_ack  = (inc == ack_cnt);
        flags.cur_zero    = (cnt == '0);
        flags.dec_zero    = (dec == '0);
        flags.dec_ones    = (dec == ONES);
    end

endmodule

// File: rtl/cyc_irq_rules.sv
module cyc_irq_rules
    import cyc_irq_pkg::*;
#(
    parameter int W = 16
) (
    input  irq_mode_e    mode,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic         en,
    input  logic         pend,
    input  logic [W-1:0] inc,
    input  logic [W-1:0] inc_msk,
    input  logic [W-1:0] dec,
    input  cmp_flags_t   flags,
    output logic [W-1:0] nxt_cnt,
    output logic         nxt_en,
    output logic         nxt_pend
);
    always_comb begin
        nxt_cnt  = cnt;
        nxt_en   = en;
        nxt_pend = pend;
        if (tick) begin
            case (mode)
                MODE_UP_LEVEL: if (en) begin
                    nxt_cnt  = inc_msk;
                    nxt_pend = flags.msk_ge_thr;
                end
                MODE_UP_RESTART: if (en) begin
                    nxt_cnt = inc;
                    if (flags.inc_ge_thr) begin
                        nxt_cnt  = '0;
                        nxt_pend = 1'b1;
                    end
                end
                MODE_UP_ONESHOT: if (en) begin
                    nxt_cnt = inc;
                    if (flags.inc_eq_thr) begin
                        nxt_pend = 1'b1;
                        nxt_en   = 1'b0;
                    end
                end
                MODE_UP_WINDOW: if (en) begin
                    nxt_cnt = inc;
                    if (flags.inc_eq_fire)
                        nxt_pend = 1'b1;
                    else if (flags.inc_eq_ack)
                        nxt_pend = 1'b0;
                end
                MODE_DN_HOLD: if (en && !flags.cur_zero) begin
                    nxt_cnt = dec;
                    if (flags.dec_zero)
                        nxt_pend = 1'b1;
                end
                MODE_DN_ONESHOT: if (en) begin
                    if (flags.cur_zero) begin
                        nxt_pend = 1'b1;
                        nxt_en   = 1'b0;
                    end else begin
                        nxt_cnt = dec;
                    end
                end
                MODE_DN_FREE: begin
                    nxt_cnt = dec;
                    if (flags.dec_ones && en)
                        nxt_pend = 1'b1;
                end
                MODE_IDLE: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
    import cyc_irq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [2:0]   mode,
    input  logic [W-1:0] thresh,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] fire_cnt,
    input  logic [W-1:0] ack_cnt,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wdata,
    input  logic         en_we,
    input  logic         en_wdata,
    input  logic         pend_we,
    input  logic         pend_wdata,
    input  logic         rld_we,
    input  logic [W-1:0] rld_wdata,
    input  logic         rld_strobe,
    input  logic         ack_strobe,
    output logic         irq_pending,
    output logic [W-1:0] count_value
);
    localparam logic [W-1:0] ONES = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         en;
        logic         pend;
        logic [W-1:0] rld;
    } state_t;

    state_t       st_d, st_q;
    irq_mode_e    mode_e;
    logic [W-1:0] inc, inc_msk, dec;
    cmp_flags_t   flags;
    logic [W-1:0] t_cnt;
    logic         t_en, t_pend;

    assign mode_e = irq_mode_e'(mode);

    cyc_irq_cmp #(.W(W)) cmp_i (
        .cnt      (st_q.cnt),
        .thresh   (thresh),
        .mask     (mask),
        .fire_cnt (fire_cnt),
        .ack_cnt  (ack_cnt),
        .inc      (inc),
        .inc_msk  (inc_msk),
        .dec      (dec),
        .flags    (flags)
    );

    cyc_irq_rules #(.W(W)) rules_i (
        .mode     (mode_e),
        .tick     (tick),
        .cnt      (st_q.cnt),
        .en       (st_q.en),
        .pend     (st_q.pend),
        .inc      (inc),
        .inc_msk  (inc_msk),
        .dec      (dec),
        .flags    (flags),
        .nxt_cnt  (t_cnt),
        .nxt_en   (t_en),
        .nxt_pend (t_pend)
    );

    // Host actions layered over the tick result, lowest priority first
    always_comb begin
        st_d      = st_q;
        st_d.cnt  = t_cnt;
        st_d.en   = t_en;
        st_d.pend = t_pend;
        if (rld_strobe) st_d.cnt  = st_q.rld;
        if (cnt_we)     st_d.cnt  = cnt_wdata;
        if (en_we)      st_d.en   = en_wdata;
        if (ack_strobe) st_d.pend = 1'b0;
        if (pend_we)    st_d.pend = pend_wdata;
        if (rld_we)     st_d.rld  = rld_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_pending = st_q.pend;
    assign count_value = st_q.cnt;

    // Assertions
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (count_value == '0 && !irq_pending));

    assert_idle_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !st_q.en && mode != 3'd6 && !cnt_we && !rld_strobe && !pend_we && !ack_strobe)
        |=> ($stable(count_value) && $stable(irq_pending)));

    assert_inert_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd7 && !cnt_we && !rld_strobe && !pend_we && !ack_strobe)
        |=> ($stable(count_value) && $stable(irq_pending)));

    assert_hold_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && count_value == '0 && !cnt_we && !rld_strobe)
        |=> (count_value == '0));

    assert_wrap_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6 && tick && st_q.en && count_value == '0 && !cnt_we && !rld_strobe
         && !pend_we && !ack_strobe)
        |=> (irq_pending && count_value == ONES));

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_strobe && !pend_we) |=> !irq_pending);

    assert_reload_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_strobe && !cnt_we) |=> (count_value == $past(st_q.rld)));

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (count_value == $past(cnt_wdata)));

    assert_pend_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pend_we |=> (irq_pending == $past(pend_wdata)));

endmodule

// File: tb/cyc_irq_timer_tb.sv
module cyc_irq_timer_tb_top;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic         tick = 0;
    logic [2:0]   mode = 0;
    logic [W-1:0] thresh = 0, mask = 0, fire_cnt = 0, ack_cnt = 0;
    logic         cnt_we = 0, en_we = 0, en_wdata = 0, pend_we = 0, pend_wdata = 0;
    logic         rld_we = 0, rld_strobe = 0, ack_strobe = 0;
    logic [W-1:0] cnt_wdata = 0, rld_wdata = 0;
    logic         irq_pending;
    logic [W-1:0] count_value;

    int checks = 0;
    int errors = 0;

    cyc_irq_timer #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .thresh(thresh), .mask(mask), .fire_cnt(fire_cnt), .ack_cnt(ack_cnt),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .en_we(en_we), .en_wdata(en_wdata),
        .pend_we(pend_we), .pend_wdata(pend_wdata), .rld_we(rld_we),
        .rld_wdata(rld_wdata), .rld_strobe(rld_strobe), .ack_strobe(ack_strobe),
        .irq_pending(irq_pending), .count_value(count_value)
    );

    typedef struct {
        logic [W-1:0] c;
        logic         e;
        logic         p;
        logic [W-1:0] r;
    } mdl_t;
    mdl_t m;

    // Expected next state from the requirements, including host priority
    function automatic mdl_t model_next(mdl_t s);
        mdl_t n = s;
        logic [W-1:0] up = s.c + 1'b1;
        if (tick) begin
            case (mode)
                3'd0: if (s.e) begin n.c = up & mask; n.p = (n.c >= thresh); end
                3'd1: if (s.e) begin
                    n.c = up;
                    if (up >= thresh) begin n.c = '0; n.p = 1'b1; end
                end
                3'd2: if (s.e) begin
                    n.c = up;
                    if (up == thresh) begin n.p = 1'b1; n.e = 1'b0; end
                end
                3'd3: if (s.e) begin
                    n.c = up;
                    if (up == fire_cnt) n.p = 1'b1;
                    else if (up == ack_cnt) n.p = 1'b0;
                end
                3'd4: if (s.e && s.c != '0) begin
                    n.c = s.c - 1'b1;
                    if (n.c == '0) n.p = 1'b1;
                end
                3'd5: if (s.e) begin
                    if (s.c == '0) begin n.p = 1'b1; n.e = 1'b0; end
                    else n.c = s.c - 1'b1;
                end
                3'd6: begin
                    n.c = s.c - 1'b1;
                    if (n.c == '1 && s.e) n.p = 1'b1;
                end
                default: ;
            endcase
        end
        if (rld_strobe) n.c = s.r;
        if (cnt_we)     n.c = cnt_wdata;
        if (en_we)      n.e = en_wdata;
        if (ack_strobe) n.p = 1'b0;
        if (pend_we)    n.p = pend_wdata;
        if (rld_we)     n.r = rld_wdata;
        return n;
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_strobes();
        cnt_we = 0; en_we = 0; pend_we = 0; rld_we = 0;
        rld_strobe = 0; ack_strobe = 0;
    endtask

    // One clock: inputs already driven at a falling edge, compare at the next one
    task automatic step(string tag);
        mdl_t x = model_next(m);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " count"}, count_value, x.c);
        chk({tag, " pending"}, W'(irq_pending), W'(x.p));
        m = x;
        clear_strobes();
    endtask

    function automatic string mode_tag(logic [2:0] md);
        case (md)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic host_setup(logic [W-1:0] c, logic e);
        cnt_we = 1; cnt_wdata = c; en_we = 1; en_wdata = e;
        pend_we = 1; pend_wdata = 0; tick = 0;
        step("R10 setup");
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'h5eed_1234);
        m = '{c: '0, e: 1'b0, p: 1'b0, r: '0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset count", count_value, '0);
        chk("R1 reset pending", W'(irq_pending), '0);
        // reload value zero after reset: strobe copies it
        cnt_we = 1; cnt_wdata = 16'h1234; step("R10 write");
        rld_strobe = 1; step("R1 reload zero");

        // R5 directed window 4096/8192
        mode = 3'd3; fire_cnt = 16'd4096; ack_cnt = 16'd8192;
        host_setup('0, 1'b1);
        tick = 1;
        for (int i = 0; i < 4096; i++) step("R5");
        chk("R5 pending at fire", W'(irq_pending), W'(1));
        for (int i = 0; i < 4096; i++) step("R5");
        chk("R5 pending at ack", W'(irq_pending), W'(0));

        // R7 directed from 5
        mode = 3'd5; host_setup(16'd5, 1'b1); tick = 1;
        for (int i = 0; i < 5; i++) step("R7");
        chk("R7 no fire before sixth", W'(irq_pending), W'(0));
        step("R7"); chk("R7 sixth fires", W'(irq_pending), W'(1));
        ack_strobe = 1; step("R10 ack");
        for (int i = 0; i < 3; i++) step("R7 disabled after fire");
        chk("R7 stays quiet", W'(irq_pending), W'(0));

        // R8 enable low: still counts, no fire
        mode = 3'd6; host_setup(16'd1, 1'b0); tick = 1;
        step("R8"); step("R8");
        chk("R8 wrapped", count_value, 16'hFFFF);
        chk("R8 no fire when disabled", W'(irq_pending), W'(0));

        // R6 hold at zero, and R11 ack beats fire
        mode = 3'd4; host_setup(16'd1, 1'b1); tick = 1; ack_strobe = 1;
        step("R11 ack with fire");
        chk("R11 counter moved", count_value, '0);
        chk("R11 pending suppressed", W'(irq_pending), W'(0));
        for (int i = 0; i < 4; i++) step("R6 hold");
        chk("R6 no refire", W'(irq_pending), W'(0));

        // R11 counter write beats tick and reload
        mode = 3'd1; thresh = 16'd100; host_setup(16'd10, 1'b1); tick = 1;
        rld_strobe = 1; cnt_we = 1; cnt_wdata = 16'd77;
        step("R11 write over tick");
        chk("R11 written value", count_value, 16'd77);

        // R12 inert mode with enable high
        mode = 3'd7; host_setup(16'd9, 1'b1); tick = 1;
        for (int i = 0; i < 5; i++) step("R12");
        chk("R12 frozen", count_value, 16'd9);

        // R2 masked wrap drops pending
        mode = 3'd0; mask = 16'h000F; thresh = 16'd12; host_setup(16'd10, 1'b1); tick = 1;
        step("R2"); chk("R2 below", W'(irq_pending), W'(0));
        step("R2"); chk("R2 at threshold", W'(irq_pending), W'(1));
        for (int i = 0; i < 4; i++) step("R2");
        chk("R2 wrapped", count_value, 16'd0);
        chk("R2 pending dropped", W'(irq_pending), W'(0));

        // Constrained random per mode
        for (int md = 0; md < 8; md++) begin
            mode = 3'(md);
            thresh   = 16'($urandom_range(1, 40));
            mask     = (16'h1 << $urandom_range(3, 7)) - 16'h1;
            fire_cnt = 16'($urandom_range(1, 30));
            ack_cnt  = fire_cnt + 16'($urandom_range(1, 30));
            host_setup(16'($urandom_range(0, 20)), 1'b1);
            for (int i = 0; i < 1500; i++) begin
                string tg;
                tick       = ($urandom_range(0, 3) != 0);
                cnt_we     = ($urandom_range(0, 39) == 0);
                cnt_wdata  = 16'($urandom_range(0, 40));
                en_we      = ($urandom_range(0, 19) == 0);
                en_wdata   = ($urandom_range(0, 3) != 0);
                pend_we    = ($urandom_range(0, 49) == 0);
                pend_wdata = 1'($urandom);
                rld_we     = ($urandom_range(0, 29) == 0);
                rld_wdata  = 16'($urandom_range(0, 40));
                rld_strobe = ($urandom_range(0, 39) == 0);
                ack_strobe = ($urandom_range(0, 19) == 0);
                if (cnt_we || pend_we || ack_strobe || rld_strobe) tg = "R11";
                else if (!m.e && md < 6 && tick) tg = "R9";
                else tg = mode_tag(3'(md));
                step(tg);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule